// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block resolves a virtual page number into its final page-table entry by reading one table entry per level from memory. Given a paging mode, the physical page number of the root table and a virtual page number, it computes the entry's physical address for the current level, issues a single read over a plain request/response port, and judges the returned entry. A pointer entry sends the walk one level further down. A leaf entry ends it with the translated page number, the raw entry, the entry's address, the level where it was found and the OR of the global bits of every entry on the path.

Four paging modes are supported. They differ in the per-level index width, the size of an entry and the level at which the walk begins. A leaf found above the lowest level is a superpage. Its low page-number bits must be zero, and in the result they are replaced by the matching virtual page-number bits. Access rights are judged outside this block: the leaf entry is shown on a port to a combinational checker, whose fail flag and code are taken back in. Faults end the walk with a code instead of a result.

Top module: `ptw_walker`

## Requirements
- R1: The entry address equals (masked base PPN << 12) | (level index << S), where S is 2 in mode 0 (32-bit entries, 10-bit index) and 3 in modes 1, 2, 3 (64-bit entries, 9-bit index). The level index for level L is the VPN slice [(L+1)*n-1 : L*n] with n the index width. `mem_size8_o` is 1 exactly when entries are 64 bits.
- R2: Mode encoding on `mode_i` is 0, 1, 2, 3 for the 32, 39, 48 and 57-bit virtual spaces. The walk begins at level 1, 2, 3 or 4 respectively and drops by exactly one level after each pointer entry. The pointer entry's PPN becomes the next base.
- R3: A read answered with `mem_err_i` high ends the walk with `fault_code_o` = 1.
- R4: An entry with V (bit 0) clear, or with W (bit 2) set while R (bit 1) is clear, ends the walk with `fault_code_o` = 2.
- R5: An entry with R and X (bit 3) both clear is a pointer. A pointer found at level 0 ends the walk with `fault_code_o` = 2.
- R6: A leaf at level L > 0 whose low n*L PPN bits are not all zero ends the walk with `fault_code_o` = 3.
- R7: On success `ppn_o` holds the leaf's PPN with its low n*L bits taken from the VPN. `pte_o`, `pte_addr_o` and `level_o` give the leaf entry, its address and its level.
- R8: On success `global_o` is the OR of the G bits (bit 5) of every entry read during the walk.
- R9: When a leaf has passed R4 and R6, a high `chk_fail_i` ends the walk with `fault_code_o` = `chk_code_i`. The checker's flag has no effect on pointer entries.
- R10: In mode 0 only data bits [31:0] form the entry. The PPN is entry bits [31:10] and only the low 22 root bits are used. In the other modes the PPN is entry bits [53:10].
- R11: At most one read is outstanding. Each level visited issues exactly one single-cycle request.
- R12: `done_o` and `fault_o` each pulse for exactly one cycle per walk and never together.
- R13: `start_i` and the walk inputs are ignored while a walk is in progress.
- R14: After reset `done_o`, `fault_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| mode_i | input | 2 | Paging mode |
| root_ppn_i | input | 44 | Root table PPN |
| vpn_i | input | 45 | Virtual page number |
| mem_req_o | output | 1 | Read request pulse |
| mem_addr_o | output | 56 | Entry physical address |
| mem_size8_o | output | 1 | 1 = 8-byte read, 0 = 4-byte read |
| mem_rsp_i | input | 1 | Read response valid |
| mem_err_i | input | 1 | Read response error |
| mem_data_i | input | 64 | Read response data |
| chk_pte_o | output | 64 | Entry presented to the permission checker |
| chk_fail_i | input | 1 | Permission checker rejects the entry |
| chk_code_i | input | 3 | Permission checker fault code |
| done_o | output | 1 | Successful completion pulse |
| fault_o | output | 1 | Fault completion pulse |
| fault_code_o | output | 3 | Fault code |
| ppn_o | output | 44 | Translated PPN |
| pte_o | output | 64 | Leaf entry |
| pte_addr_o | output | 56 | Leaf entry address |
| level_o | output | 3 | Level of the leaf |
| global_o | output | 1 | Accumulated global bit |

## Verification
The bench targets pointer entries at level 0, which a careless design would treat as a leaf or send to a negative level. It also covers superpages with a single stray low PPN bit, which would be returned as a valid translation if the alignment test were missing, and full five-level descents, where a wrong start level or index slice shows up as a wrong request address. Mode 0 responses carry noise in their upper data bits and the upper root bits, so a design that forgets to narrow them returns a wrong PPN or entry. A second start pulse during a walk checks that the captured inputs are not overwritten, since an overwrite would give a second completion or a wrong address. G bits placed only on upper-level pointers check that the global flag is accumulated over the whole path.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int PPN_W    = 44;
    localparam int VPN_W    = 45;
    localparam int PA_W     = 56;
    localparam int PTE_W    = 64;
    localparam int LVL_W    = 3;
    localparam int FLT_W    = 3;
    localparam int PAGE_OFF = 12;

    typedef logic [FLT_W-1:0] flt_t;
    localparam flt_t FLT_ACCESS   = 3'd1;
    localparam flt_t FLT_INVALID  = 3'd2;
    localparam flt_t FLT_MISALIGN = 3'd3;

    typedef enum logic [1:0] {MODE_SV32 = 2'd0, MODE_SV39 = 2'd1,
                              MODE_SV48 = 2'd2, MODE_SV57 = 2'd3} mode_e;

    typedef enum logic [1:0] {EV_DESCEND, EV_INVALID, EV_MISALIGN, EV_LEAF} eval_e;

    typedef struct packed {
        eval_e            kind;
        logic             g;
        logic [PPN_W-1:0] ppn;
    } eval_t;

    function automatic int seg_w(mode_e m);
        return (m == MODE_SV32) ? 10 : 9;
    endfunction

    function automatic logic [LVL_W-1:0] first_level(mode_e m);
        return LVL_W'(m) + LVL_W'(1);
    endfunction

    function automatic logic [PPN_W-1:0] ppn_mask(mode_e m);
        return (m == MODE_SV32) ? PPN_W'(22'h3FFFFF) : '1;
    endfunction

    function automatic logic [PPN_W-1:0] low_mask(mode_e m, logic [LVL_W-1:0] lvl);
        logic [63:0] m64;
        m64 = (64'd1 << (seg_w(m) * int'(lvl))) - 64'd1;
        return PPN_W'(m64);
    endfunction

    function automatic logic [PPN_W-1:0] pte_ppn(mode_e m, logic [PTE_W-1:0] pte);
        return (m == MODE_SV32) ? PPN_W'(pte[31:10]) : pte[53:10];
    endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  mode_e             mode_i,
    input  logic [PPN_W-1:0]  base_i,
    input  logic [VPN_W-1:0]  vpn_i,
    input  logic [LVL_W-1:0]  level_i,
    output logic [PA_W-1:0]   addr_o,
    output logic              size8_o
);
    int          w;
    logic [63:0] vsh, idx, base64, a64;
    logic        unused_hi;

    always_comb begin
        w      = seg_w(mode_i);
        vsh    = 64'(vpn_i) >> (w * int'(level_i));
        idx    = vsh & ((64'd1 << w) - 64'd1);
        base64 = 64'(base_i & ppn_mask(mode_i));
        a64    = (base64 << PAGE_OFF) | (idx << ((mode_i == MODE_SV32) ? 2 : 3));
    end

    assign addr_o    = a64[PA_W-1:0];
    assign size8_o   = (mode_i != MODE_SV32);
    assign unused_hi = ^a64[63:PA_W];
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
    import ptw_pkg::*;
(
    input  mode_e             mode_i,
    input  logic [LVL_W-1:0]  level_i,
    input  logic [VPN_W-1:0]  vpn_i,
    input  logic [PTE_W-1:0]  pte_i,
    output eval_t             res_o
);
    logic [PPN_W-1:0] ppn, lm;
    logic             fv, fr, fw, fx;
    logic             unused_bits;

    always_comb begin
        fv = pte_i[0];
        fr = pte_i[1];
        fw = pte_i[2];
        fx = pte_i[3];
        ppn = pte_ppn(mode_i, pte_i);
        lm  = low_mask(mode_i, level_i);
        res_o.g   = pte_i[5];
        res_o.ppn = ppn;
        if (!fv || (fw && !fr))
            res_o.kind = EV_INVALID;
        else if (!fr && !fx)
            res_o.kind = (level_i != '0) ? EV_DESCEND : EV_INVALID;
        else if ((ppn & lm) != '0)
            res_o.kind = EV_MISALIGN;
        else begin
            res_o.kind = EV_LEAF;
            res_o.ppn  = (ppn & ~lm) | (vpn_i[PPN_W-1:0] & lm);
        end
    end

    assign unused_bits = ^{pte_i[63:54], pte_i[9:6], pte_i[4], vpn_i[VPN_W-1:PPN_W]};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [43:0]       root_ppn_i,
    input  logic [44:0]       vpn_i,
    output logic              mem_req_o,
    output logic [55:0]       mem_addr_o,
    output logic              mem_size8_o,
    input  logic              mem_rsp_i,
    input  logic              mem_err_i,
    input  logic [63:0]       mem_data_i,
    output logic [63:0]       chk_pte_o,
    input  logic              chk_fail_i,
    input  logic [2:0]        chk_code_i,
    output logic              done_o,
    output logic              fault_o,
    output logic [2:0]        fault_code_o,
    output logic [43:0]       ppn_o,
    output logic [63:0]       pte_o,
    output logic [55:0]       pte_addr_o,
    output logic [2:0]        level_o,
    output logic              global_o
);
    typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_EVAL} st_e;

    st_e              state_q;
    mode_e            mode_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] base_q;
    logic [LVL_W-1:0] level_q;
    logic             glob_q;
    logic [PTE_W-1:0] pte_q;
    logic [PA_W-1:0]  addr_w;
    logic             size8_w;
    eval_t            ev;

    ptw_addr_gen u_addr (
        .mode_i (mode_q), .base_i (base_q), .vpn_i (vpn_q), .level_i (level_q),
        .addr_o (addr_w), .size8_o (size8_w)
    );

    ptw_pte_eval u_eval (
        .mode_i (mode_q), .level_i (level_q), .vpn_i (vpn_q), .pte_i (pte_q),
        .res_o  (ev)
    );

    assign mem_req_o   = (state_q == S_REQ);
    assign mem_addr_o  = addr_w;
    assign mem_size8_o = size8_w;
    assign chk_pte_o   = pte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_IDLE;
            mode_q       <= MODE_SV32;
            vpn_q        <= '0;
            base_q       <= '0;
            level_q      <= '0;
            glob_q       <= 1'b0;
            pte_q        <= '0;
            done_o       <= 1'b0;
            fault_o      <= 1'b0;
            fault_code_o <= '0;
            ppn_o        <= '0;
            pte_o        <= '0;
            pte_addr_o   <= '0;
            level_o      <= '0;
            global_o     <= 1'b0;
        end else begin
            done_o  <= 1'b0;
            fault_o <= 1'b0;
            case (state_q)
                S_IDLE: if (start_i) begin
                    mode_q  <= mode_e'(mode_i);
                    vpn_q   <= vpn_i;
                    base_q  <= root_ppn_i & ppn_mask(mode_e'(mode_i));
                    level_q <= first_level(mode_e'(mode_i));
                    glob_q  <= 1'b0;
                    state_q <= S_REQ;
                end
                S_REQ: state_q <= S_WAIT;
                S_WAIT: if (mem_rsp_i) begin
                    if (mem_err_i) begin
                        fault_o      <= 1'b1;
                        fault_code_o <= FLT_ACCESS;
                        state_q      <= S_IDLE;
                    end else begin
                        pte_q   <= (mode_q == MODE_SV32) ? PTE_W'(mem_data_i[31:0]) : mem_data_i;
                        state_q <= S_EVAL;
                    end
                end
                S_EVAL: begin
                    state_q <= S_IDLE;
                    case (ev.kind)
                        EV_DESCEND: begin
                            base_q  <= ev.ppn;
                            level_q <= level_q - LVL_W'(1);
                            glob_q  <= glob_q | ev.g;
                            state_q <= S_REQ;
                        end
                        EV_INVALID: begin
                            fault_o      <= 1'b1;
                            fault_code_o <= FLT_INVALID;
                        end
                        EV_MISALIGN: begin
                            fault_o      <= 1'b1;
                            fault_code_o <= FLT_MISALIGN;
                        end
                        default: begin
                            if (chk_fail_i) begin
                                fault_o      <= 1'b1;
                                fault_code_o <= chk_code_i;
                            end else begin
                                done_o     <= 1'b1;
                                ppn_o      <= ev.ppn;
                                pte_o      <= pte_q;
                                pte_addr_o <= addr_w;
                                level_o    <= level_q;
                                global_o   <= glob_q | ev.g;
                            end
                        end
                    endcase
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R11
    req_single_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |=> !mem_req_o);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R12
    fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fault_o |=> !fault_o);

    // R12
    done_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_o && fault_o));

    // R2
    level_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_REQ && $past(state_q) == S_EVAL) |-> level_q == $past(level_q) - LVL_W'(1));

    // R13
    inputs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_IDLE) |=> ($stable(vpn_q) && $stable(mode_q)));

    // R6
    misalign_level_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_EVAL && ev.kind == EV_MISALIGN) |-> level_q != '0);
endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [43:0] root_ppn_i = '0;
    logic [44:0] vpn_i = '0;
    logic        mem_req_o, mem_size8_o;
    logic [55:0] mem_addr_o;
    logic        mem_rsp_i = 1'b0, mem_err_i = 1'b0;
    logic [63:0] mem_data_i = '0;
    logic [63:0] chk_pte_o;
    logic        chk_fail_i = 1'b0;
    logic [2:0]  chk_code_i = '0;
    logic        done_o, fault_o, global_o;
    logic [2:0]  fault_code_o, level_o;
    logic [43:0] ppn_o;
    logic [63:0] pte_o;
    logic [55:0] pte_addr_o;

    always #2.5 clk = ~clk;

    ptw_walker uut (.*);

    int checks = 0, errors = 0;

    // scenario table and expectations
    logic [63:0] t_addr [5];
    logic [63:0] t_data [5];
    bit          t_err  [5];
    int          fk [5];
    int          fmode, ffail, fg;
    int          sl, cur_lv, req_count, exp_reqs, exp_fault;
    bit          exp_size8, lv0_ptr;
    logic [63:0] exp_ppn, exp_pte, exp_addr;
    int          exp_code, exp_level;
    bit          exp_glob;
    logic [63:0] s_root, s_vpn;
    int          s_mode;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int pick(input int lv);
        int r = $urandom % 100;
        if (lv > 0) return (r < 55) ? 0 : (r < 75) ? 1 : (r < 85) ? 2 : (r < 93) ? 3 : 4;
        return (r < 70) ? 1 : (r < 80) ? 0 : (r < 90) ? 3 : 4;
    endfunction

    task automatic build();
        int w, pw, lg, k;
        bit fin, g, r, wb, x;
        logic [63:0] base, idx, a, ppn, lm, data, flags;
        s_mode = (fmode < 0) ? int'($urandom % 4) : fmode;
        w  = (s_mode == 0) ? 10 : 9;
        pw = (s_mode == 0) ? 22 : 44;
        lg = (s_mode == 0) ? 2 : 3;
        sl = s_mode + 1;
        s_vpn  = {$urandom, $urandom} & ((64'd1 << ((sl + 1) * w)) - 1);
        s_root = {$urandom, $urandom} & ((64'd1 << 44) - 1);
        base = s_root & ((64'd1 << pw) - 1);
        exp_size8 = (s_mode != 0);
        chk_fail_i = (ffail < 0) ? ($urandom % 5 == 0) : ffail[0];
        chk_code_i = 3'(4 + $urandom % 4);
        exp_glob = 0; exp_reqs = 0; fin = 0; lv0_ptr = 0; exp_fault = 0;
        for (int lv = sl; lv >= 0 && !fin; lv--) begin
            idx = (s_vpn >> (lv * w)) & ((64'd1 << w) - 1);
            a   = (base << 12) | (idx << lg);
            k   = (fk[lv] >= 0) ? fk[lv] : pick(lv);
            ppn = {$urandom, $urandom} & ((64'd1 << pw) - 1);
            lm  = (64'd1 << (w * lv)) - 1;
            g   = (fg == -1) ? ($urandom % 4 == 0) : (lv == fg);
            if (k == 2 && lv == 0) k = 1;
            flags = 64'($urandom & 8'hD0) | (64'(g) << 5);
            if (k == 1 || k == 2) begin
                r = $urandom; wb = $urandom; x = $urandom;
                if (!r && !x) r = 1;
                if (wb) r = 1;
                flags |= 64'd1 | (64'(r) << 1) | (64'(wb) << 2) | (64'(x) << 3);
                if (k == 1) ppn &= ~lm;
                else ppn |= 64'd1 << ($urandom % (w * lv));
            end else if (k == 0) flags |= 64'd1;
            else if (k == 3) flags |= ($urandom % 2) ? 64'h4 | 64'h1 : 64'h8;
            data = (ppn << 10) | flags;
            if (s_mode == 0) data[63:32] = $urandom;
            else data[63:54] = 10'($urandom);
            t_addr[lv] = a; t_data[lv] = data; t_err[lv] = (k == 4);
            exp_reqs++;
            if (k == 4) begin exp_fault = 1; exp_code = 1; fin = 1; end
            else if (k == 3) begin exp_fault = 1; exp_code = 2; fin = 1; end
            else if (k == 0) begin
                exp_glob |= g;
                if (lv > 0) base = ppn;
                else begin exp_fault = 1; exp_code = 2; lv0_ptr = 1; fin = 1; end
            end else if (k == 2) begin exp_fault = 1; exp_code = 3; fin = 1; end
            else begin
                exp_glob |= g;
                fin = 1;
                if (chk_fail_i) begin exp_fault = 1; exp_code = int'(chk_code_i); end
                else begin
                    exp_ppn   = (ppn & ~lm) | (s_vpn & lm);
                    exp_pte   = (s_mode == 0) ? (data & 64'hFFFF_FFFF) : data;
                    exp_addr  = a;
                    exp_level = lv;
                end
            end
        end
    endtask

    // memory responder
    initial begin
        logic [63:0] a;
        forever begin
            @(negedge clk);
            if (mem_req_o) begin
                a = 64'(mem_addr_o);
                req_count++;
                chk(mem_size8_o == exp_size8, "R1 size", 64'(mem_size8_o), 64'(exp_size8));
                chk(cur_lv >= 0 && a == t_addr[cur_lv >= 0 ? cur_lv : 0], "R1 addr", a,
                    t_addr[cur_lv >= 0 ? cur_lv : 0]);
                repeat (1 + $urandom % 3) @(negedge clk);
                mem_rsp_i = 1'b1;
                mem_err_i = (cur_lv < 0) ? 1'b1 : t_err[cur_lv];
                mem_data_i = (cur_lv < 0) ? 64'($urandom) : t_data[cur_lv];
                cur_lv--;
                @(negedge clk);
                mem_rsp_i = 1'b0; mem_err_i = 1'b0;
            end
        end
    end

    task automatic run_walk(input bit inject);
        int n;
        build();
        req_count = 0; cur_lv = sl;
        @(negedge clk);
        mode_i = 2'(s_mode); root_ppn_i = s_root[43:0]; vpn_i = s_vpn[44:0]; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 1;
        while (!(done_o || fault_o) && n < 400) begin
            if (inject && n == 1) begin
                start_i = 1'b1; vpn_i = ~vpn_i; mode_i = ~mode_i; root_ppn_i = ~root_ppn_i;
            end
            if (inject && n == 2) start_i = 1'b0;
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        chk(done_o == (exp_fault == 0), "R12 done", 64'(done_o), 64'(exp_fault == 0));
        chk(fault_o == (exp_fault != 0), "R12 fault", 64'(fault_o), 64'(exp_fault != 0));
        if (exp_fault != 0) begin
            chk(int'(fault_code_o) == exp_code,
                lv0_ptr ? "R5 code" : exp_code == 1 ? "R3 code" : exp_code == 2 ? "R4 code" :
                exp_code == 3 ? "R6 code" : "R9 code", 64'(fault_code_o), 64'(exp_code));
        end else begin
            chk(64'(ppn_o) == exp_ppn, "R7 ppn", 64'(ppn_o), exp_ppn);
            chk(pte_o == exp_pte, "R10 pte", pte_o, exp_pte);
            chk(64'(pte_addr_o) == exp_addr, "R7 addr", 64'(pte_addr_o), exp_addr);
            chk(int'(level_o) == exp_level, "R2 level", 64'(level_o), 64'(exp_level));
            chk(global_o == exp_glob, "R8 global", 64'(global_o), 64'(exp_glob));
        end
        chk(req_count == exp_reqs, "R11 requests", 64'(req_count), 64'(exp_reqs));
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!done_o && !fault_o && !mem_req_o, inject ? "R13 quiet" : "R12 quiet",
                64'({done_o, fault_o, mem_req_o}), 64'd0);
        end
    endtask

    task automatic set_kinds(input int k4, input int k3, input int k2, input int k1, input int k0);
        fk[4] = k4; fk[3] = k3; fk[2] = k2; fk[1] = k1; fk[0] = k0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        set_kinds(-1, -1, -1, -1, -1);
        fmode = -1; ffail = -1; fg = -1; cur_lv = -1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done_o && !fault_o && !mem_req_o, "R14 reset", 64'({done_o, fault_o, mem_req_o}), 64'd0);

        // R10 mode 0: pointer then 4K leaf
        fmode = 0; ffail = 0; set_kinds(-1, -1, -1, 0, 1); run_walk(0);
        // R7 mode 1 aligned top-level superpage
        fmode = 1; set_kinds(-1, -1, 1, -1, -1); run_walk(0);
        // R2 mode 3 full descent
        fmode = 3; set_kinds(0, 0, 0, 0, 1); run_walk(0);
        // R5 pointer at level 0
        fmode = 2; set_kinds(-1, 0, 0, 0, 0); run_walk(0);
        // R6 misaligned middle superpage
        fmode = 1; set_kinds(-1, -1, 0, 2, -1); run_walk(0);
        // R4 invalid at top
        fmode = 2; set_kinds(-1, 3, -1, -1, -1); run_walk(0);
        // R3 memory error at level 0
        fmode = 0; set_kinds(-1, -1, -1, 0, 4); run_walk(0);
        // R9 permission failure after pointers
        fmode = 1; ffail = 1; set_kinds(-1, -1, 0, 0, 1); run_walk(0);
        // R8 G only on the top pointer; then none
        fmode = 2; ffail = 0; fg = 3; set_kinds(-1, 0, 0, 0, 1); run_walk(0);
        fg = -2; run_walk(0);
        // R13 start during a deep walk
        fmode = 3; fg = -1; set_kinds(0, 0, 0, 0, 1); run_walk(1);

        fmode = -1; ffail = -1; set_kinds(-1, -1, -1, -1, -1);
        for (int i = 0; i < 300; i++) run_walk($urandom % 4 == 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule